// File: doc/BRIEF.md
# Transceiver Diagnostic Flag Register and Error Indicator

This block keeps the diagnostic state of a bus transceiver: a power-on flag, a wake-up flag, a flag recording that the wake-up came from the local wake pin, a bus-failure flag and a local-failure flag. It also recognizes wake-up requests. A local request is a level change on the wake pin, in either direction, that persists for a filter time. A remote request is a dominant bus level that persists for a bus wake time. The mode controller supplies the current operating mode. The block keeps the mode it came from and uses both to choose which flag drives an active-low error output.

In the low-power modes, the wake-up flag is also shown on a receive-data wake output, so the host sees the request on two pins. In normal mode, the error output first shows the wake-source flag. After the transmit-data line has made four dominant-to-recessive transitions, it shows the bus-failure flag instead. In listen-only mode it shows local failure when the previous mode was normal, and power-on otherwise. Setting the power-on or wake-up flag raises a one-cycle request to clear the undervoltage flag kept elsewhere.

Top module: `diag_flag_unit`

## Requirements
- R1: Mode codes are 0 normal, 1 listen-only, 2 standby, 3 go-to-sleep, 4 sleep; codes 2 to 7 count as low-power. In a low-power mode, `err_n_o` and `rxd_wake_n_o` are both low exactly when the wake-up flag is set. Outside low-power modes, `rxd_wake_n_o` is high.
- R2: A local wake-up event occurs when `wake_pin_i` differs from its last accepted level on WAKE_FILT_CYC consecutive clock edges, in either direction. A shorter excursion produces no event.
- R3: A remote wake-up event occurs when `bus_dom_i` is high on BUS_WAKE_CYC consecutive edges. A shorter dominant pulse produces no event.
- R4: The wake-up flag (`flags_o[1]`) sets on a wake-up event only while the mode is low-power and `uv_wait_i` is low.
- R5: Setting the power-on flag (`flags_o[0]`, from `pwon_evt_i`) or the wake-up flag pulses `uv_clr_o` high for one cycle. A power-on event also clears the wake-up and wake-source flags.
- R6: The wake-source flag (`flags_o[2]`) sets only when a local event sets the wake-up flag while the power-on flag is clear. It clears when the mode leaves normal.
- R7: Entering normal mode clears the power-on, wake-up, bus-failure and local-failure flags, and restarts the transmit-edge count.
- R8: In normal mode, `err_n_o` shows the wake-source flag until the fourth dominant-to-recessive edge on `txd_i` (0 to 1) after entry. From that edge on, it shows the bus-failure flag.
- R9: The bus-failure flag (`flags_o[3]`) sets in normal mode when `bus_short_i` was seen during the dominant phase of four consecutive `txd_i` cycles. A cycle without a short restarts the run.
- R10: In listen-only mode, `err_n_o` shows the local-failure flag if the previous mode was normal, and shows the power-on flag otherwise.
- R11: The local-failure flag (`flags_o[4]`) sets while `local_fail_i` is high in normal or listen-only mode. It clears when `local_fail_i` is low while `bus_dom_i` is high and `txd_i` is high.
- R12: After reset, all flags are clear, `err_n_o` and `rxd_wake_n_o` are high, and `uv_clr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current operating mode code |
| wake_pin_i | input | 1 | Synchronized local wake pin level |
| bus_dom_i | input | 1 | Bus currently dominant |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| pwon_evt_i | input | 1 | Battery power-on event |
| bus_short_i | input | 1 | Bus short detected |
| local_fail_i | input | 1 | Any local failure present |
| uv_wait_i | input | 1 | Undervoltage waiting time running |
| flags_o | output | 5 | Flags: 0 power-on, 1 wake-up, 2 wake source, 3 bus failure, 4 local failure |
| err_n_o | output | 1 | Active-low error indication |
| rxd_wake_n_o | output | 1 | Active-low wake indication for the receive pin |
| uv_clr_o | output | 1 | One-cycle request to clear undervoltage state |

## Verification
The wake filters are tried with excursions one cycle shorter than the filter window and with excursions exactly as long as it. This separates a correct window length from one that is off by one cycle. Runs of transmit cycles are driven with the short present on every cycle, and also with one clean cycle in the middle. These runs show whether the bus-failure counter demands consecutive cycles, and whether the error output switches on exactly the fourth edge. Listen-only mode is entered both from normal and from standby, so the previous-mode selection becomes visible. Wake events are also presented during the undervoltage wait and in normal mode, where they must leave the flags unchanged.

// File: rtl/diag_pkg.sv
package diag_pkg;
    localparam logic [2:0] MD_NORMAL  = 3'd0;
    localparam logic [2:0] MD_LISTEN  = 3'd1;
    localparam logic [2:0] MD_STANDBY = 3'd2;

    localparam int FLAG_W  = 5;
    localparam int FL_PWON = 0;
    localparam int FL_WAKE = 1;
    localparam int FL_WSRC = 2;
    localparam int FL_BUSF = 3;
    localparam int FL_LFAIL = 4;

    function automatic logic is_low_power(input logic [2:0] m);
        return m >= MD_STANDBY;
    endfunction
endpackage

// File: rtl/wake_level_filter.sv
module wake_level_filter #(
    parameter int FILT_CYC = 6,
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic evt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          ref_lvl;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = 1'b0;
        if (pin_i != st_q.ref_lvl) begin
            if (st_q.cnt == CW'(FILT_CYC - 1)) begin
                evt_o       = 1'b1;
                st_d.ref_lvl = pin_i;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ref_lvl: IDLE_LVL, cnt: '0};
        else        st_q <= st_d;
    end

    // R2
    filt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(FILT_CYC));
endmodule

// File: rtl/bus_dom_timer.sv
module bus_dom_timer #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_i,
    output logic evt_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = 1'b0;
        if (dom_i) begin
            if (st_q.cnt == CW'(HOLD_CYC - 1)) evt_o = 1'b1;
            if (st_q.cnt != CW'(HOLD_CYC)) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    one_evt_per_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
endmodule

// File: rtl/txd_cycle_mon.sv
module txd_cycle_mon #(
    parameter int EDGE_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic restart_i,
    input  logic txd_i,
    input  logic short_i,
    output logic limit_o,
    output logic fail_set_o
);
    localparam int CW = $clog2(EDGE_LIM + 1);

    typedef struct packed {
        logic          txd;
        logic          seen;
        logic [CW-1:0] edges;
        logic [CW-1:0] run;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d       = st_q;
        st_d.txd   = txd_i;
        fail_set_o = 1'b0;
        rise       = !st_q.txd && txd_i;
        if (restart_i) begin
            st_d.seen  = 1'b0;
            st_d.edges = '0;
            st_d.run   = '0;
        end else if (active_i) begin
            if (rise) begin
                if (st_q.edges != CW'(EDGE_LIM)) st_d.edges = st_q.edges + 1'b1;
                if (st_q.seen) begin
                    if (st_q.run == CW'(EDGE_LIM - 1)) fail_set_o = 1'b1;
                    if (st_q.run != CW'(EDGE_LIM)) st_d.run = st_q.run + 1'b1;
                end else begin
                    st_d.run = '0;
                end
                st_d.seen = 1'b0;
            end else if (!txd_i && short_i) begin
                st_d.seen = 1'b1;
            end
        end
    end

    assign limit_o = (st_q.edges == CW'(EDGE_LIM));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{txd: 1'b1, seen: 1'b0, edges: '0, run: '0};
        else        st_q <= st_d;
    end

    // R8
    edge_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.edges <= CW'(EDGE_LIM));
    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !limit_o);
endmodule

// File: rtl/diag_flag_unit.sv
module diag_flag_unit
    import diag_pkg::*;
#(
    parameter int WAKE_FILT_CYC = 6,
    parameter int BUS_WAKE_CYC  = 3,
    parameter int TXD_EDGES     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              wake_pin_i,
    input  logic              bus_dom_i,
    input  logic              txd_i,
    input  logic              pwon_evt_i,
    input  logic              bus_short_i,
    input  logic              local_fail_i,
    input  logic              uv_wait_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              err_n_o,
    output logic              rxd_wake_n_o,
    output logic              uv_clr_o
);
    typedef struct packed {
        logic [2:0]        cur;
        logic [2:0]        prev;
        logic [FLAG_W-1:0] flags;
        logic              uvclr;
    } st_t;

    st_t  st_d, st_q;
    logic loc_evt, rem_evt, edge_lim, busf_hit;
    logic enter_norm, leave_norm, wake_set, sel;

    wake_level_filter #(.FILT_CYC(WAKE_FILT_CYC), .IDLE_LVL(1'b0)) u_loc (
        .clk(clk), .rst_n(rst_n), .pin_i(wake_pin_i), .evt_o(loc_evt));

    bus_dom_timer #(.HOLD_CYC(BUS_WAKE_CYC)) u_rem (
        .clk(clk), .rst_n(rst_n), .dom_i(bus_dom_i), .evt_o(rem_evt));

    txd_cycle_mon #(.EDGE_LIM(TXD_EDGES)) u_txd (
        .clk(clk), .rst_n(rst_n), .active_i(mode_i == MD_NORMAL),
        .restart_i(enter_norm), .txd_i(txd_i), .short_i(bus_short_i),
        .limit_o(edge_lim), .fail_set_o(busf_hit));

    always_comb begin
        st_d       = st_q;
        st_d.uvclr = 1'b0;
        st_d.cur   = mode_i;
        if (mode_i != st_q.cur) st_d.prev = st_q.cur;
        enter_norm = (mode_i == MD_NORMAL) && (st_q.cur != MD_NORMAL);
        leave_norm = (mode_i != MD_NORMAL) && (st_q.cur == MD_NORMAL);
        wake_set   = (loc_evt || rem_evt) && is_low_power(mode_i)
                     && !uv_wait_i && !pwon_evt_i;

        if (enter_norm) begin
            st_d.flags[FL_PWON]  = 1'b0;
            st_d.flags[FL_WAKE]  = 1'b0;
            st_d.flags[FL_BUSF]  = 1'b0;
            st_d.flags[FL_LFAIL] = 1'b0;
        end
        if (leave_norm) st_d.flags[FL_WSRC] = 1'b0;
        if (busf_hit) st_d.flags[FL_BUSF] = 1'b1;

        if (local_fail_i && (mode_i == MD_NORMAL || mode_i == MD_LISTEN))
            st_d.flags[FL_LFAIL] = 1'b1;
        else if (!local_fail_i && bus_dom_i && txd_i)
            st_d.flags[FL_LFAIL] = 1'b0;

        if (wake_set) begin
            st_d.flags[FL_WAKE] = 1'b1;
            st_d.uvclr          = 1'b1;
            if (loc_evt && !st_q.flags[FL_PWON]) st_d.flags[FL_WSRC] = 1'b1;
        end
        if (pwon_evt_i) begin
            st_d.flags[FL_PWON] = 1'b1;
            st_d.flags[FL_WAKE] = 1'b0;
            st_d.flags[FL_WSRC] = 1'b0;
            st_d.uvclr          = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: MD_STANDBY, prev: MD_STANDBY, flags: '0, uvclr: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.cur == MD_NORMAL)
            sel = edge_lim ? st_q.flags[FL_BUSF] : st_q.flags[FL_WSRC];
        else if (st_q.cur == MD_LISTEN)
            sel = (st_q.prev == MD_NORMAL) ? st_q.flags[FL_LFAIL] : st_q.flags[FL_PWON];
        else
            sel = st_q.flags[FL_WAKE];
    end

    assign flags_o      = st_q.flags;
    assign err_n_o      = !sel;
    assign rxd_wake_n_o = !(is_low_power(st_q.cur) && st_q.flags[FL_WAKE]);
    assign uv_clr_o     = st_q.uvclr;

    // R1
    lp_pins_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_low_power(st_q.cur) |-> (err_n_o == rxd_wake_n_o));
    // R4
    wake_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FL_WAKE]) |-> $past(is_low_power(mode_i) && !uv_wait_i));
    // R5
    wake_uvclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FL_WAKE]) |-> uv_clr_o);
    // R6
    wsrc_pwon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FL_WSRC]) |-> !$past(flags_o[FL_PWON]));
    // R7
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_NORMAL && st_q.cur != MD_NORMAL && !pwon_evt_i)
        |=> !flags_o[FL_PWON] && !flags_o[FL_WAKE]);
    // R9
    busf_after_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FL_BUSF]) |-> edge_lim);
endmodule

// File: tb/diag_flag_unit_tb_top.sv
module diag_flag_unit_tb_top;
    localparam int F = 6;
    localparam int B = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd2;
    logic       wake_pin = 1'b0, bus_dom = 1'b0, txd = 1'b1;
    logic       pwon_evt = 1'b0, bus_short = 1'b0, local_fail = 1'b0, uv_wait = 1'b0;
    logic [4:0] flags;
    logic       err_n, rxd_n, uvclr;
    int         checks = 0, fails = 0;

    always #10 clk = ~clk;

    diag_flag_unit #(.WAKE_FILT_CYC(F), .BUS_WAKE_CYC(B), .TXD_EDGES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .wake_pin_i(wake_pin),
        .bus_dom_i(bus_dom), .txd_i(txd), .pwon_evt_i(pwon_evt),
        .bus_short_i(bus_short), .local_fail_i(local_fail), .uv_wait_i(uv_wait),
        .flags_o(flags), .err_n_o(err_n), .rxd_wake_n_o(rxd_n), .uv_clr_o(uvclr));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic txd_cycle(input logic shorted);
        txd = 1'b0; bus_short = shorted; tick(1);
        txd = 1'b1; bus_short = 1'b0;    tick(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R12 flags", flags, 0);
        chk("R12 err", err_n, 1);
        chk("R12 rxd", rxd_n, 1);
        chk("R12 uvclr", uvclr, 0);

        pwon_evt = 1'b1; tick(1); pwon_evt = 1'b0;
        chk("R5 pwon set", flags, 5'b00001);
        chk("R5 uvclr pulse", uvclr, 1);
        tick(1);
        chk("R5 uvclr one cycle", uvclr, 0);
        chk("R1 standby no wake", err_n, 1);

        mode = 3'd1; tick(1);
        chk("R10 listen from standby shows pwon", err_n, 0);

        mode = 3'd2; tick(1);
        wake_pin = 1'b1; tick(F - 1);
        chk("R2 short of window", flags, 5'b00001);
        tick(1);
        chk("R6 local wake with pwon set, no source", flags, 5'b00011);
        chk("R1 err shows wake", err_n, 0);
        chk("R1 rxd shows wake", rxd_n, 0);

        mode = 3'd0; tick(1);
        chk("R7 entry clears pwon/wake", flags, 0);
        chk("R8 normal shows source", err_n, 1);
        chk("R1 rxd high in normal", rxd_n, 1);

        mode = 3'd2; tick(1);
        wake_pin = 1'b0; tick(F - 1); wake_pin = 1'b1; tick(3);
        chk("R2 falling glitch rejected", flags, 0);
        wake_pin = 1'b0; tick(F);
        chk("R6 falling local wake sets source", flags, 5'b00110);

        mode = 3'd0; tick(1);
        chk("R7 wake cleared, source kept", flags, 5'b00100);
        chk("R8 source shown before edges", err_n, 0);
        for (int i = 0; i < 3; i++) txd_cycle(1'b0);
        chk("R8 three edges still source", err_n, 0);
        txd_cycle(1'b0);
        chk("R8 fourth edge shows bus failure", err_n, 1);
        for (int i = 0; i < 3; i++) txd_cycle(1'b1);
        txd_cycle(1'b0);
        for (int i = 0; i < 3; i++) txd_cycle(1'b1);
        chk("R9 broken run no failure", flags[3], 0);
        txd_cycle(1'b1);
        chk("R9 four consecutive shorts", flags[3], 1);
        chk("R8 err shows bus failure", err_n, 0);

        mode = 3'd1; tick(1);
        chk("R6 source cleared leaving normal", flags, 5'b01000);
        chk("R10 listen from normal shows local", err_n, 1);
        local_fail = 1'b1; tick(1); local_fail = 1'b0;
        chk("R11 local failure set", flags[4], 1);
        chk("R10 err shows local failure", err_n, 0);
        bus_dom = 1'b1; tick(1); bus_dom = 1'b0;
        chk("R11 local failure cleared", flags[4], 0);

        mode = 3'd0; tick(1);
        chk("R7 busf cleared on reentry", flags, 0);

        mode = 3'd3; tick(1);
        bus_dom = 1'b1; tick(B - 1); bus_dom = 1'b0; tick(2);
        chk("R3 short dominant rejected", flags, 0);
        bus_dom = 1'b1; tick(B);
        chk("R3 remote wake", flags, 5'b00010);
        chk("R5 uvclr on wake", uvclr, 1);
        chk("R1 rxd wake in go-to-sleep", rxd_n, 0);
        bus_dom = 1'b0;

        mode = 3'd0; tick(1);
        mode = 3'd4; uv_wait = 1'b1; tick(1);
        wake_pin = 1'b1; tick(F + 2);
        chk("R4 blocked during uv wait", flags, 0);
        uv_wait = 1'b0; wake_pin = 1'b0; tick(F);
        chk("R4 wake in sleep", flags, 5'b00110);

        mode = 3'd0; tick(1);
        wake_pin = 1'b1; tick(F + 2);
        chk("R4 ignored in normal", flags, 5'b00100);

        mode = 3'd2; tick(1);
        chk("R6 leave normal clears source", flags, 0);
        wake_pin = 1'b0; tick(F);
        chk("R2 wake set again", flags, 5'b00110);
        pwon_evt = 1'b1; tick(1); pwon_evt = 1'b0;
        chk("R5 pwon clears wake and source", flags, 5'b00001);
        chk("R5 uvclr on pwon", uvclr, 1);

        mode = 3'd1; tick(1);
        chk("R10 listen from standby pwon again", err_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule